// File: doc/BRIEF.md
# Dual-Source DRAM Refresh Timer

This block paces row refresh for a dynamic memory array. It raises a refresh request at a steady rate and presents the row address that the memory sequencer should strobe next. The sequencer answers each request with an acknowledge pulse. That acknowledge retires one pending request and steps the row address.

Two timing sources feed the block:

- **Normal operation.** The block counts cycles of its own clock, which is the system bus clock. A programmable limit sets the interval so that it can be held at or below the per-row budget of the memory parts. For the larger parts, 512 rows in 8 ms gives at most 15.6 µs per row.
- **Power failure.** The bus clock is no longer a valid time base. The block then takes its pace from a slow backup oscillator input, which is asynchronous. That input is synchronized and its rising edges are detected. Every second rising edge produces one request, so an oscillator with a period of at most 7.5 µs gives a request every 15 µs.

A density select chooses how many rows the address counter spans: 256 rows for the smaller parts or 512 for the larger ones.

Top module: `rfsh_timer`

## Requirements
- R1: While `rst_n` is low and directly after reset, `rf_req` is 0 and `rf_row` is 0.
- R2: With `pwr_fail` low, the bus-clock divider signals one interval every `div_lim`+1 clock cycles. The first interval ends on the (`div_lim`+1)-th rising edge after reset release, and `rf_req` is 1 after that edge.
- R3: A pending request persists until it is acknowledged. An edge with `rf_ack`=1 and `rf_req`=1 retires exactly one pending request, and `rf_req` falls after that edge when it was the only one.
- R4: `rf_ack` while `rf_req` is 0 has no effect: the row address and the request state do not change.
- R5: At most two requests can be pending. An interval that ends while two are pending is dropped, so two acknowledges then clear `rf_req`.
- R6: With `pwr_fail` high, the bus-clock divider produces no interval, and its count restarts from zero.
- R7: With `pwr_fail` high, `bkup_osc` is passed through a two-flop synchronizer. Every second synchronized rising edge (the 2nd, 4th, and so on since `pwr_fail` rose) produces one interval, and odd edges produce none.
- R8: The row address increments by one on each accepted acknowledge and holds otherwise.
- R9: With `dense`=0 the row address wraps from 255 to 0. With `dense`=1 it wraps from 511 to 0.
- R10: When an interval ends on the same edge as an accepted acknowledge, the pending count is unchanged: `rf_req` stays 1 and the row still advances.
- R11: When `pwr_fail` falls, the divide-by-two phase of the backup path is cleared, so a later power failure again needs two oscillator edges. The bus divider restarts, giving its first interval `div_lim`+1 cycles after `pwr_fail` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (bus clock in normal operation) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | High selects the backup oscillator as the time base |
| bkup_osc | input | 1 | Asynchronous backup oscillator |
| dense | input | 1 | 0: 256-row parts, 1: 512-row parts |
| div_lim | input | DIV_W | Bus-clock interval is div_lim+1 cycles |
| rf_ack | input | 1 | Refresh done, retires one pending request |
| rf_req | output | 1 | At least one refresh request pending |
| rf_row | output | ROW_W | Row address for the next refresh |

## Verification
The end of an interval and an acknowledge can land on the same clock edge. The pending count must then stay put while the row still advances.

The bench provokes this collision in two ways:

- It raises the acknowledge in the cycle just before a bus interval is known to end, with one request already pending. It then expects the request to remain and the row to step by one.
- It sets the interval limit to zero and holds the acknowledge high for hundreds of cycles. Every edge then collides, so the request must stay high while the row runs through both wrap points.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   // Density select encoding: the smaller parts span the low row count.
   typedef enum logic {
      DENS_LO = 1'b0,
      DENS_HI = 1'b1
   } dens_e;

endpackage

// File: rtl/rfsh_bus_div.sv
// Bus-clock interval divider: one tick every lim+1 cycles while not held.
module rfsh_bus_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [DIV_W-1:0] lim,
   output logic             tick
);

   if (DIV_W < 2) begin : g_chk_w
      $error("rfsh_bus_div: DIV_W must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             at_lim;

   // >= so that lowering lim below the running count never stalls the divider
   assign at_lim = (cnt_q >= lim);
   assign tick   = at_lim & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hold || at_lim) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rfsh_bkup_div.sv
// Backup oscillator path: synchronizer, rising-edge detect, optional divide by two.
module rfsh_bkup_div #(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_BY      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic osc,
   output logic tick
);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("rfsh_bkup_div: SYNC_STAGES must be at least 2");
   end
   if (DIV_BY != 1 && DIV_BY != 2) begin : g_chk_div
      $error("rfsh_bkup_div: DIV_BY must be 1 or 2");
   end

   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] sync_q;
   logic         last_q;
   logic         rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], osc};
         last_q <= sync_q[MSB];
      end
   end

   assign rise = sync_q[MSB] & ~last_q;

   if (DIV_BY == 2) begin : g_half
      logic half_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= 1'b0;
         end else if (!enable) begin
            half_q <= 1'b0;
         end else if (rise) begin
            half_q <= ~half_q;
         end
      end
      assign tick = enable & rise & half_q;

      // R11: phase is clear on the cycle after the path was disabled
      half_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !enable |=> !half_q);
   end else begin : g_full
      assign tick = enable & rise;
   end

endmodule

// File: rtl/rfsh_pend.sv
// Pending-request counter with saturation.
module rfsh_pend #(
   parameter int MAX_PEND = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ack,
   output logic req,
   output logic take
);

   if (MAX_PEND < 1) begin : g_chk_cap
      $error("rfsh_pend: MAX_PEND must be at least 1");
   end

   localparam int            CW  = $clog2(MAX_PEND + 1);
   localparam logic [CW-1:0] CAP = CW'(MAX_PEND);

   logic [CW-1:0] cnt_q;

   assign req  = (cnt_q != '0);
   assign take = ack & req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({tick, take})
            2'b10:   if (cnt_q < CAP) cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req);

   // R4
   stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req && !tick |=> !req);

   // R10
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && take |=> req && cnt_q == $past(cnt_q));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP);

endmodule

// File: rtl/rfsh_row_ctr.sv
// Refresh row address counter with density-dependent wrap.
module rfsh_row_ctr
   import rfsh_pkg::*;
#(
   parameter int ROW_W   = 9,
   parameter int LO_ROWS = 256,
   parameter int HI_ROWS = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dense,
   output logic [ROW_W-1:0] row
);

   if (HI_ROWS > (1 << ROW_W)) begin : g_chk_w
      $error("rfsh_row_ctr: HI_ROWS does not fit ROW_W");
   end
   if (LO_ROWS < 2 || LO_ROWS >= HI_ROWS) begin : g_chk_rows
      $error("rfsh_row_ctr: need 2 <= LO_ROWS < HI_ROWS");
   end

   localparam logic [ROW_W-1:0] LO_LAST = ROW_W'(LO_ROWS - 1);
   localparam logic [ROW_W-1:0] HI_LAST = ROW_W'(HI_ROWS - 1);

   dens_e            dsel;
   logic [ROW_W-1:0] last;

   assign dsel = dens_e'(dense);
   assign last = (dsel == DENS_HI) ? HI_LAST : LO_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (inc) begin
         row <= (row == last) ? '0 : row + 1'b1;
      end
   end

   // R8
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(row));

   // R9
   row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && row == last |=> row == '0);

endmodule

// File: rtl/rfsh_timer.sv
// Dual-source refresh timer top.
module rfsh_timer #(
   parameter int DIV_W       = 16,
   parameter int ROW_W       = 9,
   parameter int LO_ROWS     = 256,
   parameter int HI_ROWS     = 512,
   parameter int MAX_PEND    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int BKUP_DIV    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail,
   input  logic             bkup_osc,
   input  logic             dense,
   input  logic [DIV_W-1:0] div_lim,
   input  logic             rf_ack,
   output logic             rf_req,
   output logic [ROW_W-1:0] rf_row
);

   logic bus_tick;
   logic bk_tick;
   logic any_tick;
   logic take;

   rfsh_bus_div #(.DIV_W(DIV_W)) bus_div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (pwr_fail),
      .lim   (div_lim),
      .tick  (bus_tick)
   );

   rfsh_bkup_div #(.SYNC_STAGES(SYNC_STAGES), .DIV_BY(BKUP_DIV)) bkup_div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (pwr_fail),
      .osc    (bkup_osc),
      .tick   (bk_tick)
   );

   assign any_tick = bus_tick | bk_tick;

   rfsh_pend #(.MAX_PEND(MAX_PEND)) pend_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (any_tick),
      .ack   (rf_ack),
      .req   (rf_req),
      .take  (take)
   );

   rfsh_row_ctr #(.ROW_W(ROW_W), .LO_ROWS(LO_ROWS), .HI_ROWS(HI_ROWS)) row_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (take),
      .dense (dense),
      .row   (rf_row)
   );

   // R6
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |-> !bus_tick);

   // R7
   bkup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_fail |-> !bk_tick);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> !rf_req && rf_row == '0);

endmodule

// File: tb/rfsh_timer_tb.sv
module rfsh_timer_tb_top;

   localparam int DIV_W = 16;
   localparam int ROW_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pwr_fail = 1'b0;
   logic             bkup_osc = 1'b0;
   logic             dense = 1'b0;
   logic [DIV_W-1:0] div_lim = DIV_W'(9);
   logic             rf_ack = 1'b0;
   logic             rf_req;
   logic [ROW_W-1:0] rf_row;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   int    q_req[$];
   int    q_row[$];
   string q_tag[$];

   always #5 clk = ~clk;

   rfsh_timer dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_fail (pwr_fail),
      .bkup_osc (bkup_osc),
      .dense    (dense),
      .div_lim  (div_lim),
      .rf_ack   (rf_ack),
      .rf_req   (rf_req),
      .rf_row   (rf_row)
   );

   // Monitor: pops expected items and compares at the falling edge.
   always @(negedge clk) begin
      while (q_req.size() > 0) begin
         int    er;
         int    ew;
         string tg;
         er = q_req.pop_front();
         ew = q_row.pop_front();
         tg = q_tag.pop_front();
         n_chk++;
         if (int'(rf_req) != er || int'(rf_row) != ew) begin
            n_bad++;
            $display("FAIL %s: actual req=%0d row=%0d expected req=%0d row=%0d",
                     tg, rf_req, rf_row, er, ew);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // Driver side: push the expectation, let the monitor consume it.
   task automatic expect_out(input int er, input int ew, input string tg);
      q_req.push_back(er);
      q_row.push_back(ew);
      q_tag.push_back(tg);
      @(negedge clk);
      #1;
   endtask

   task automatic ack_once();
      rf_ack = 1'b1;
      step(1);
      rf_ack = 1'b0;
   endtask

   task automatic osc_pulse();
      bkup_osc = 1'b1;
      step(5);
      bkup_osc = 1'b0;
      step(5);
   endtask

   initial begin : wdog
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin : stim
      step(3);
      expect_out(0, 0, "R1 during reset");
      rst_n = 1'b1;
      step(9);
      expect_out(0, 0, "R2 before first interval");
      step(1);
      expect_out(1, 0, "R2 first interval");
      ack_once();
      expect_out(0, 1, "R3 ack clears single request, R8 row step");
      ack_once();
      expect_out(0, 1, "R4 stray ack ignored");
      step(7);
      expect_out(0, 1, "R2 one cycle before second interval");
      step(1);
      expect_out(1, 1, "R2 second interval");
      step(20);
      rf_ack = 1'b1;
      step(1);
      expect_out(1, 2, "R5 two pending after three intervals");
      step(1);
      rf_ack = 1'b0;
      expect_out(0, 3, "R5 third interval dropped");
      step(8);
      expect_out(1, 3, "R2 interval after queue drained");
      step(9);
      rf_ack = 1'b1;
      step(1);
      rf_ack = 1'b0;
      expect_out(1, 4, "R10 interval and ack on same edge");
      ack_once();
      expect_out(0, 5, "R3 ack after collision");
      // Collide on every edge: limit zero, ack held high.
      div_lim = '0;
      step(1);
      rf_ack = 1'b1;
      step(250);
      expect_out(1, 255, "R10 req held under continuous collision, R8");
      step(1);
      expect_out(1, 0, "R9 low density wrap 255 to 0");
      dense = 1'b1;
      step(511);
      expect_out(1, 511, "R9 high density reaches 511");
      step(1);
      expect_out(1, 0, "R9 high density wrap 511 to 0");
      rf_ack = 1'b0;
      step(1);
      // Power fail: the bus divider must fall silent.
      pwr_fail = 1'b1;
      rf_ack = 1'b1;
      step(2);
      rf_ack = 1'b0;
      expect_out(0, 2, "R6 queue drained under power fail");
      step(30);
      expect_out(0, 2, "R6 no bus intervals under power fail");
      osc_pulse();
      expect_out(0, 2, "R7 first oscillator edge gives nothing");
      osc_pulse();
      expect_out(1, 2, "R7 second oscillator edge gives request");
      ack_once();
      osc_pulse();
      expect_out(0, 3, "R7 third oscillator edge gives nothing");
      osc_pulse();
      expect_out(1, 3, "R7 fourth oscillator edge gives request");
      ack_once();
      osc_pulse();
      expect_out(0, 4, "R7 fifth oscillator edge gives nothing");
      div_lim = DIV_W'(9);
      pwr_fail = 1'b0;
      step(9);
      expect_out(0, 4, "R11 bus divider restarted from zero");
      step(1);
      expect_out(1, 4, "R11 first bus interval after power returns");
      rf_ack = 1'b1;
      pwr_fail = 1'b1;
      step(1);
      rf_ack = 1'b0;
      expect_out(0, 5, "R11 ack on re-entry to power fail");
      osc_pulse();
      expect_out(0, 5, "R11 divide phase was cleared");
      osc_pulse();
      expect_out(1, 5, "R11 request on second edge after re-entry");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule